// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block sits beside the execute stage of a 32-bit core. Each cycle it looks at a pending synchronous exception (with its 12-bit event code) and at the interrupt controller's best pending source (vector and priority level). It decides whether an event is taken. If one is, it performs the whole entry state update at the next clock edge.

On entry the block saves the status register, program counter and stack register into their shadow copies. It then raises the privileged, blocked and bank bits in the status register and records the event code. Finally it produces the handler address. That address is either fixed (for the reset class) or an offset from the vector base register that depends on the event class.

The core feeds the updated PC and SR back to the execute stage on the cycle the taken strobe is high. It also uses the `ds_clr` and `wake_clr` strobes to drop its delay-slot and wake-from-sleep state.

Top module: `exc_entry_seq`

## Requirements
- R1: When `exc_pend` is high an exception is taken: `taken_exc` pulses and `taken_irq` stays low, regardless of the interrupt inputs.
- R2: If SR bit 28 (blocked) is set, a pending exception whose code is not 0x1E0 is recorded and handled as code 0x000; code 0x1E0 keeps its own code.
- R3: With SR bit 28 set, an interrupt is ignored unless `wake` is high. `wake_clr` pulses in the cycle of any entry taken while SR bit 28 was set.
- R4: An interrupt is taken only if `irq_req` is high and `irq_level` is strictly greater than SR[7:4]. A request that is not taken leaves every registered output unchanged.
- R5: On entry, `ssr` gets the old SR, `sgr` gets R15, and `new_sr` is the old SR with bits 30, 29 and 28 set.
- R6: On entry with `in_dslot` high, the saved PC is `pc` minus 2 and `ds_clr` pulses for one cycle.
- R7: Exception codes 0x000, 0x020 and 0x140 clear SR bit 15, set SR[7:4] to 0xF and load `new_pc` with 0xA0000000.
- R8: Exception codes 0x040 and 0x060 load `new_pc` with VBR+0x400. Every other exception loads VBR+0x100.
- R9: For code 0x160 the saved PC is advanced by 2 after any delay-slot rewind.
- R10: An exception writes its effective code to `expevt`. An interrupt writes `irq_vec` to `intevt`, loads VBR+0x600, and leaves `expevt` unchanged.
- R11: All outputs update at the first clock edge after the request. `taken_exc` and `taken_irq` are one-cycle pulses and never high together. After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| exc_pend | input | 1 | Synchronous exception pending |
| exc_code | input | 12 | Event code of the pending exception |
| irq_req | input | 1 | Interrupt controller has a pending source |
| irq_vec | input | 12 | Vector code of that source |
| irq_level | input | 4 | Priority level of that source |
| wake | input | 1 | Core is waking from sleep |
| in_dslot | input | 1 | Current instruction sits in a branch delay slot |
| sr | input | 32 | Current status register |
| pc | input | 32 | Current program counter |
| r15 | input | 32 | Current stack register |
| vbr | input | 32 | Vector base register |
| new_pc | output | 32 | Handler entry address |
| new_sr | output | 32 | Status register after entry |
| ssr | output | 32 | Saved status register |
| spc | output | 32 | Saved program counter |
| sgr | output | 32 | Saved stack register |
| expevt | output | 12 | Last exception event code |
| intevt | output | 12 | Last interrupt vector code |
| taken_exc | output | 1 | Exception accepted this cycle |
| taken_irq | output | 1 | Interrupt accepted this cycle |
| ds_clr | output | 1 | Clear delay-slot state |
| wake_clr | output | 1 | Clear wake-from-sleep state |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a 4-bit priority mask and 2-byte instructions. With these values every SR field, vector offset and the ±2 saved-PC adjustment are exercised at their real positions. Directed cases hit each reset-class code, both TLB-miss codes, the trap code, the 0x1E0 exemption under the blocked bit, and interrupt levels equal to and one above the mask. A randomised run then mixes all of these with delay slots and wake.

// File: rtl/exc_entry_pkg.sv
// Package: SR field positions, event codes and event class type
// shared by the entry sequencer and its sub-blocks.
package exc_entry_pkg;
    localparam int CODE_W  = 12;
    localparam int SR_BL   = 28;
    localparam int SR_RB   = 29;
    localparam int SR_MD   = 30;
    localparam int SR_FD   = 15;
    localparam int SR_IM_L = 4;

    localparam logic [CODE_W-1:0] C_POWER  = 12'h000;
    localparam logic [CODE_W-1:0] C_MANRST = 12'h020;
    localparam logic [CODE_W-1:0] C_MULTI  = 12'h140;
    localparam logic [CODE_W-1:0] C_MISS_R = 12'h040;
    localparam logic [CODE_W-1:0] C_MISS_W = 12'h060;
    localparam logic [CODE_W-1:0] C_TRAP   = 12'h160;
    localparam logic [CODE_W-1:0] C_EXEMPT = 12'h1E0;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_EXC  = 2'd1,
        EV_IRQ  = 2'd2
    } ev_cls_e;
endpackage

// File: rtl/exc_accept.sv
// Decides which event class is taken this cycle and the effective
// exception code. Assumes irq_level/irq_req come from a controller
// that already picked its highest pending source.
module exc_accept
    import exc_entry_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic              exc_pend,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              irq_req,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic [LVL_W-1:0]  imask,
    input  logic              blocked,
    input  logic              wake,
    output ev_cls_e           cls,
    output logic [CODE_W-1:0] eff_code
);
    // Exceptions win; interrupts need priority above mask and no block.
    always_comb begin
        eff_code = exc_code;
        cls      = EV_NONE;
        if (exc_pend) begin
            cls = EV_EXC;
            if (blocked && exc_code != C_EXEMPT)
                eff_code = C_POWER;
        end else if (irq_req && (!blocked || wake) && irq_level > imask) begin
            cls = EV_IRQ;
        end
    end
endmodule

// File: rtl/exc_target.sv
// Computes handler address and post-entry SR from event class and code.
// Assumes eff_code already carries the blocked-state promotion.
module exc_target
    import exc_entry_pkg::*;
#(
    parameter int          XLEN    = 32,
    parameter int          LVL_W   = 4,
    parameter logic [31:0] RST_VEC = 32'hA000_0000,
    parameter logic [31:0] OFS_GEN = 32'h100,
    parameter logic [31:0] OFS_TLB = 32'h400,
    parameter logic [31:0] OFS_IRQ = 32'h600
) (
    input  ev_cls_e           cls,
    input  logic [CODE_W-1:0] eff_code,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   vbr,
    output logic [XLEN-1:0]   tgt_pc,
    output logic [XLEN-1:0]   tgt_sr
);
    localparam int IM_H = SR_IM_L + LVL_W - 1;

    // Selects vector and adjusts SR fields per event class.
    always_comb begin
        tgt_sr        = sr;
        tgt_sr[SR_BL] = 1'b1;
        tgt_sr[SR_RB] = 1'b1;
        tgt_sr[SR_MD] = 1'b1;
        tgt_pc        = vbr + XLEN'(OFS_GEN);
        if (cls == EV_IRQ) begin
            tgt_pc = vbr + XLEN'(OFS_IRQ);
        end else if (eff_code == C_POWER || eff_code == C_MANRST || eff_code == C_MULTI) begin
            tgt_sr[SR_FD]        = 1'b0;
            tgt_sr[IM_H:SR_IM_L] = '1;
            tgt_pc               = XLEN'(RST_VEC);
        end else if (eff_code == C_MISS_R || eff_code == C_MISS_W) begin
            tgt_pc = vbr + XLEN'(OFS_TLB);
        end
    end
endmodule

// File: rtl/exc_save.sv
// Computes the saved PC: rewinds over a delay-slot branch and steps
// past a trap instruction. Assumes fixed-size instructions.
module exc_save
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 2
) (
    input  ev_cls_e           cls,
    input  logic [CODE_W-1:0] eff_code,
    input  logic              in_dslot,
    input  logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   saved_pc
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Applies rewind then trap advance.
    always_comb begin
        saved_pc = in_dslot ? pc - STEP : pc;
        if (cls == EV_EXC && eff_code == C_TRAP)
            saved_pc = saved_pc + STEP;
    end
endmodule

// File: rtl/exc_entry_seq.sv
// Top: exception/interrupt entry sequencer. Registers the entry state
// update one clock after a request. Assumes the core applies new_pc and
// new_sr in the cycle taken_exc or taken_irq is high.
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int LVL_W      = 4,
    parameter int INSN_BYTES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_pend,
    input  logic [11:0]       exc_code,
    input  logic              irq_req,
    input  logic [11:0]       irq_vec,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              wake,
    input  logic              in_dslot,
    input  logic [XLEN-1:0]   sr,
    input  logic [XLEN-1:0]   pc,
    input  logic [XLEN-1:0]   r15,
    input  logic [XLEN-1:0]   vbr,
    output logic [XLEN-1:0]   new_pc,
    output logic [XLEN-1:0]   new_sr,
    output logic [XLEN-1:0]   ssr,
    output logic [XLEN-1:0]   spc,
    output logic [XLEN-1:0]   sgr,
    output logic [11:0]       expevt,
    output logic [11:0]       intevt,
    output logic              taken_exc,
    output logic              taken_irq,
    output logic              ds_clr,
    output logic              wake_clr
);
    localparam int IM_H = SR_IM_L + LVL_W - 1;

    ev_cls_e           cls;
    logic [CODE_W-1:0] eff_code;
    logic [XLEN-1:0]   tgt_pc, tgt_sr, saved_pc;
    logic              take;

    assign take = (cls != EV_NONE);

    exc_accept #(.LVL_W(LVL_W)) u_accept (
        .exc_pend (exc_pend),
        .exc_code (exc_code),
        .irq_req  (irq_req),
        .irq_level(irq_level),
        .imask    (sr[IM_H:SR_IM_L]),
        .blocked  (sr[SR_BL]),
        .wake     (wake),
        .cls      (cls),
        .eff_code (eff_code)
    );

    exc_target #(.XLEN(XLEN), .LVL_W(LVL_W)) u_target (
        .cls     (cls),
        .eff_code(eff_code),
        .sr      (sr),
        .vbr     (vbr),
        .tgt_pc  (tgt_pc),
        .tgt_sr  (tgt_sr)
    );

    exc_save #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_save (
        .cls     (cls),
        .eff_code(eff_code),
        .in_dslot(in_dslot),
        .pc      (pc),
        .saved_pc(saved_pc)
    );

    // Entry state registers: load on a taken event, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            new_pc <= '0;
            new_sr <= '0;
            ssr    <= '0;
            spc    <= '0;
            sgr    <= '0;
            expevt <= '0;
            intevt <= '0;
        end else if (take) begin
            new_pc <= tgt_pc;
            new_sr <= tgt_sr;
            ssr    <= sr;
            spc    <= saved_pc;
            sgr    <= r15;
            if (cls == EV_EXC) expevt <= eff_code;
            else               intevt <= irq_vec;
        end
    end

    // Single-cycle strobes describing the accepted event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_exc <= 1'b0;
            taken_irq <= 1'b0;
            ds_clr    <= 1'b0;
            wake_clr  <= 1'b0;
        end else begin
            taken_exc <= (cls == EV_EXC);
            taken_irq <= (cls == EV_IRQ);
            ds_clr    <= take && in_dslot;
            wake_clr  <= take && sr[SR_BL];
        end
    end

    // Exception beats interrupt.
    p_exc_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend |=> taken_exc && !taken_irq);

    // Blocked-state promotion reaches EXPEVT.
    p_block_promote_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pend && sr[SR_BL] && exc_code != C_EXEMPT |=> expevt == C_POWER);

    // Blocked and not waking: no interrupt entry.
    p_block_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sr[SR_BL] && !wake && !exc_pend |=> !taken_irq);

    // Level at or below mask: nothing moves.
    p_mask_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_pend && irq_level <= sr[IM_H:SR_IM_L] |=> $stable(new_pc) && $stable(spc) && !taken_irq);

    // Shadow copies and raised SR bits.
    p_save_r5: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> ssr == $past(sr) && sgr == $past(r15) && new_sr[SR_MD] && new_sr[SR_RB] && new_sr[SR_BL]);

    // Strobes never overlap.
    p_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({taken_exc, taken_irq}));
endmodule

// File: tb/exc_entry_seq_test.sv
module exc_entry_seq_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        exc_pend, irq_req, wake, in_dslot;
    logic [11:0] exc_code, irq_vec;
    logic [3:0]  irq_level;
    logic [31:0] sr, pc, r15, vbr;
    logic [31:0] new_pc, new_sr, ssr, spc, sgr;
    logic [11:0] expevt, intevt;
    logic        taken_exc, taken_irq, ds_clr, wake_clr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Reference state
    logic [31:0] m_pc, m_sr, m_ssr, m_spc, m_sgr;
    logic [11:0] m_exp, m_int;
    logic        m_te, m_ti, m_ds, m_wk;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_seq uut (.*);

    task automatic chk32(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk32("R11 taken_exc", 32'(taken_exc), 32'(m_te));
        chk32("R1 taken_irq",  32'(taken_irq), 32'(m_ti));
        chk32("R7/R8/R10 new_pc", new_pc, m_pc);
        chk32("R5/R7 new_sr", new_sr, m_sr);
        chk32("R5 ssr", ssr, m_ssr);
        chk32("R6/R9 spc", spc, m_spc);
        chk32("R5 sgr", sgr, m_sgr);
        chk32("R2/R10 expevt", 32'(expevt), 32'(m_exp));
        chk32("R10 intevt", 32'(intevt), 32'(m_int));
        chk32("R6 ds_clr", 32'(ds_clr), 32'(m_ds));
        chk32("R3 wake_clr", 32'(wake_clr), 32'(m_wk));
    endtask

    // Behavioural model of one clock edge from the requirement text.
    task automatic model_step();
        bit bl, ex, ir;
        logic [11:0] code;
        logic [31:0] sp;
        bl = sr[28];
        ex = exc_pend;
        ir = !exc_pend && irq_req && (!bl || wake) && (int'(irq_level) > int'(sr[7:4]));
        m_te = ex; m_ti = ir;
        m_ds = (ex || ir) && in_dslot;
        m_wk = (ex || ir) && bl;
        if (ex || ir) begin
            m_ssr = sr; m_sgr = r15;
            m_sr  = sr | 32'h7000_0000;
            sp = in_dslot ? pc - 2 : pc;
            if (ex) begin
                code = (bl && exc_code != 12'h1E0) ? 12'h000 : exc_code;
                m_exp = code;
                if (code == 12'h160) sp = sp + 2;
                if (code == 12'h000 || code == 12'h020 || code == 12'h140) begin
                    m_sr[15] = 1'b0; m_sr[7:4] = 4'hF; m_pc = 32'hA000_0000;
                end else if (code == 12'h040 || code == 12'h060) m_pc = vbr + 32'h400;
                else m_pc = vbr + 32'h100;
            end else begin
                m_int = irq_vec; m_pc = vbr + 32'h600;
            end
            m_spc = sp;
        end
    endtask

    task automatic cycle(bit ep, logic [11:0] ec, bit iq, logic [11:0] iv, logic [3:0] lv,
                         bit wk, bit ds, logic [31:0] s, logic [31:0] p);
        exc_pend = ep; exc_code = ec; irq_req = iq; irq_vec = iv; irq_level = lv;
        wake = wk; in_dslot = ds; sr = s; pc = p;
        r15 = p ^ 32'h5A5A_0000; vbr = 32'h8C00_0000 + {p[15:8], 8'h00};
        model_step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all();
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [11:0] codes [12] = '{12'h000, 12'h020, 12'h040, 12'h060, 12'h080, 12'h0A0,
                                   12'h0C0, 12'h100, 12'h140, 12'h160, 12'h180, 12'h1E0};
        rst_n = 1'b0;
        exc_pend = 0; exc_code = 0; irq_req = 0; irq_vec = 0; irq_level = 0;
        wake = 0; in_dslot = 0; sr = 0; pc = 0; r15 = 0; vbr = 0;
        {m_pc, m_sr, m_ssr, m_spc, m_sgr} = '0;
        {m_exp, m_int} = '0;
        {m_te, m_ti, m_ds, m_wk} = '0;
        repeat (2) @(posedge clk);
        #(CLK_PERIOD/4);
        compare_all();  // R11 reset state
        rst_n = 1'b1;

        // R1 exception beats interrupt
        cycle(1, 12'h0A0, 1, 12'h320, 4'hF, 0, 0, 32'h0000_0000, 32'h0000_1000);
        // R11 idle holds, strobes drop
        cycle(0, 12'h000, 0, 12'h000, 4'h0, 0, 0, 32'h0000_0000, 32'h0000_2000);
        // R2 promotion under BL, exemption for 0x1E0
        cycle(1, 12'h180, 0, 12'h000, 4'h0, 0, 0, 32'h1000_80F0, 32'h0000_3000);
        cycle(1, 12'h1E0, 0, 12'h000, 4'h0, 0, 0, 32'h1000_0000, 32'h0000_3100);
        // R3 blocked interrupt ignored, then taken with wake
        cycle(0, 12'h000, 1, 12'h400, 4'hF, 0, 0, 32'h1000_0000, 32'h0000_4000);
        cycle(0, 12'h000, 1, 12'h400, 4'hF, 1, 0, 32'h1000_0000, 32'h0000_4100);
        // R4 level equal to mask ignored, one above taken
        cycle(0, 12'h000, 1, 12'h520, 4'h5, 0, 0, 32'h0000_0050, 32'h0000_5000);
        cycle(0, 12'h000, 1, 12'h520, 4'h6, 0, 0, 32'h0000_0050, 32'h0000_5100);
        // R6 delay-slot rewind, R8 TLB vector
        cycle(1, 12'h040, 0, 12'h000, 4'h0, 0, 1, 32'h0000_0000, 32'h0000_6000);
        cycle(1, 12'h060, 0, 12'h000, 4'h0, 0, 0, 32'h0000_0000, 32'h0000_6100);
        // R7 reset-class codes
        cycle(1, 12'h020, 0, 12'h000, 4'h0, 0, 0, 32'h0000_8030, 32'h0000_7000);
        cycle(1, 12'h140, 0, 12'h000, 4'h0, 0, 0, 32'h0000_8000, 32'h0000_7100);
        // R9 trap advance, with and without delay slot
        cycle(1, 12'h160, 0, 12'h000, 4'h0, 0, 0, 32'h0000_0000, 32'h0000_8000);
        cycle(1, 12'h160, 0, 12'h000, 4'h0, 0, 1, 32'h0000_0000, 32'h0000_8100);
        // R10 interrupt keeps expevt
        cycle(0, 12'h000, 1, 12'h7A0, 4'h9, 0, 1, 32'h0000_0020, 32'h0000_9000);

        for (int i = 0; i < 400; i++) begin
            cycle($urandom_range(0, 2) == 0, codes[$urandom_range(0, 11)],
                  1'($urandom), 12'($urandom), 4'($urandom), 1'($urandom), 1'($urandom),
                  {1'b0, 3'($urandom), 12'($urandom), 8'($urandom), 8'($urandom)}, $urandom);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule